// File: doc/BRIEF.md
# Five-Stage Pipelined 32-bit Integer Core

This block is a small in-order 32-bit processor core. Each instruction passes through five stages: fetch, decode with register read, execute, memory access and writeback. One instruction can enter per clock once the pipeline is full. It executes eight operations: add, subtract, and, or, signed set-less-than, load word, store word and branch-if-equal. The instruction store and the data store are separate internal word arrays, so a fetch and a data access never compete for the same storage.

A bench or host fills both arrays through a preload port while reset is held, then releases reset. Execution starts from address zero. Results produced by older instructions are bypassed to younger ones from the pipeline registers. A load whose result is needed by the very next instruction costs one bubble. Branches are assumed not taken; a taken branch squashes the three younger instructions already in flight. Every instruction that reaches writeback appears on a retire port, and a read-only debug port exposes the register file and the data array.

Top module: `pipe5_core`

## Requirements
- R1: Word layout is opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], 16-bit immediate [15:0]. Opcode 0x00 with function 0x20/0x22/0x24/0x25/0x2A writes rd with rs+rt, rs-rt, rs&rt, rs|rt, or 1/0 from a signed rs<rt comparison.
- R2: Opcode 0x23 loads rt from data word at index addr[AW+1:2], and opcode 0x2B stores rt there. In both cases addr is rs plus the sign-extended immediate, and the low two address bits are ignored.
- R3: Register 0 always reads as zero, is never written, and is never bypassed; a retire that targets register 0 shows the write flag low.
- R4: An instruction consuming a result of either of the two instructions ahead of it receives that result, with the nearer producer taking priority.
- R5: A register written in writeback is read with its new value by the instruction in decode in that same cycle.
- R6: When a load is directly followed by an instruction that reads the load's nonzero destination, that instruction retires two cycles after the load instead of one.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next retired instruction is the one at branch PC + 4 + 4*sext(imm), retiring four cycles after the branch, and no wrong-path instruction retires. When they differ, there is no penalty.
- R8: Instructions retire in program order. The first retires 4 clock edges after reset is released, and each later one retires 1 cycle after its predecessor unless R6 or R7 applies.
- R9: During reset the retire port is idle, all registers read zero, and fetch restarts at address 0.
- R10: The preload port writes the instruction array when ld_sel is 0 and the data array when ld_sel is 1.
- R11: Any other encoding retires as a no-operation: it writes no register, writes no memory and causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Preload write strobe |
| ld_sel | input | 1 | Preload target: 0 instruction array, 1 data array |
| ld_addr | input | AW | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_reg_sel | input | 5 | Debug register index |
| dbg_reg_val | output | 32 | Register file contents at dbg_reg_sel |
| dbg_mem_sel | input | AW | Debug data-array index |
| dbg_mem_val | output | 32 | Data-array word at dbg_mem_sel |
| ret_valid | output | 1 | An instruction is in writeback this cycle |
| ret_pc | output | 32 | Address of the retiring instruction |
| ret_we | output | 1 | Retiring instruction writes a register |
| ret_rd | output | 5 | Destination register of the retiring instruction |
| ret_data | output | 32 | Value written to ret_rd |

## Verification
The bench runs an instruction-level model alongside the core. For every retirement it predicts the cycle the instruction must appear: four edges after reset for the first, then one more cycle per instruction, plus one after a load-use pair, plus three after a taken branch. It samples the retire port at the falling edge of exactly that cycle. Store results are read through the debug port at the falling edge where the store retires, one edge after the data array was written. Three randomly generated programs, weighted toward arithmetic, loads and branches, cover the bypass, stall and flush corners.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  input  logic [4:0]    dbg_reg_sel,
  output logic [31:0]   dbg_reg_val,
  input  logic [AW-1:0] dbg_mem_sel,
  output logic [31:0]   dbg_mem_val,
  output logic          ret_valid,
  output logic [31:0]   ret_pc,
  output logic          ret_we,
  output logic [4:0]    ret_rd,
  output logic [31:0]   ret_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [5:0] OP_R = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25, FN_SLT = 6'h2A;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf [32];
  logic [31:0] pc;

  logic        fd_v;
  logic [31:0] fd_ir, fd_pc4;

  logic        de_v, de_lw, de_sw, de_beq, de_we;
  logic [5:0]  de_fn;
  logic [4:0]  de_rs, de_rt, de_dst;
  logic [31:0] de_a, de_b, de_imm, de_pc4;

  logic        em_v, em_lw, em_sw, em_beq, em_we, em_zero;
  logic [4:0]  em_dst;
  logic [31:0] em_alu, em_sd, em_tgt, em_pc4;

  logic        mw_v, mw_we;
  logic [4:0]  mw_dst;
  logic [31:0] mw_val, mw_pc4;

  // decode
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd;
  logic [31:0] imm, rd_a, rd_b;
  logic        fn_ok, is_r, is_lw, is_sw, is_beq, uses_rs, uses_rt, wb_w, stall, take;

  assign op = fd_ir[31:26];
  assign fn = fd_ir[5:0];
  assign rs = fd_ir[25:21];
  assign rt = fd_ir[20:16];
  assign rd = fd_ir[15:11];
  assign imm = {{16{fd_ir[15]}}, fd_ir[15:0]};
  assign fn_ok = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) || (fn == FN_OR) || (fn == FN_SLT);
  assign is_r = (op == OP_R) && fn_ok;
  assign is_lw = (op == OP_LW);
  assign is_sw = (op == OP_SW);
  assign is_beq = (op == OP_BEQ);
  assign uses_rs = is_r | is_lw | is_sw | is_beq;
  assign uses_rt = is_r | is_sw | is_beq;
  assign wb_w = mw_v & mw_we;

  assign rd_a = (rs == 5'd0) ? 32'd0 : (wb_w && mw_dst == rs) ? mw_val : rf[rs];
  assign rd_b = (rt == 5'd0) ? 32'd0 : (wb_w && mw_dst == rt) ? mw_val : rf[rt];

  assign stall = fd_v & de_v & de_lw & de_we &
                 ((uses_rs & (rs == de_dst)) | (uses_rt & (rt == de_dst)));

  // execute
  logic [31:0] fa, fb, opb, alu;
  always_comb begin
    fa = de_a;
    if (em_v && em_we && em_dst == de_rs) fa = em_alu;
    else if (mw_v && mw_we && mw_dst == de_rs) fa = mw_val;
    fb = de_b;
    if (em_v && em_we && em_dst == de_rt) fb = em_alu;
    else if (mw_v && mw_we && mw_dst == de_rt) fb = mw_val;
  end
  assign opb = (de_lw | de_sw) ? de_imm : fb;

  always_comb begin
    case (de_fn)
      FN_SUB:  alu = fa - opb;
      FN_AND:  alu = fa & opb;
      FN_OR:   alu = fa | opb;
      FN_SLT:  alu = {31'd0, $signed(fa) < $signed(opb)};
      default: alu = fa + opb;
    endcase
  end

  // memory
  logic [31:0] mem_rd;
  assign mem_rd = dmem[em_alu[AW+1:2]];
  assign take = em_v & em_beq & em_zero;

  always_ff @(posedge clk)
    if (ld_we && !ld_sel) imem[ld_addr] <= ld_data;

  always_ff @(posedge clk)
    if (ld_we && ld_sel) dmem[ld_addr] <= ld_data;
    else if (em_v && em_sw) dmem[em_alu[AW+1:2]] <= em_sd;

  always_ff @(posedge clk)
    if (!rst_n) for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    else if (wb_w) rf[mw_dst] <= mw_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= 32'd0;
      fd_v <= 1'b0; fd_ir <= 32'd0; fd_pc4 <= 32'd0;
      de_v <= 1'b0; de_lw <= 1'b0; de_sw <= 1'b0; de_beq <= 1'b0; de_we <= 1'b0;
      de_fn <= 6'd0; de_rs <= 5'd0; de_rt <= 5'd0; de_dst <= 5'd0;
      de_a <= 32'd0; de_b <= 32'd0; de_imm <= 32'd0; de_pc4 <= 32'd0;
      em_v <= 1'b0; em_lw <= 1'b0; em_sw <= 1'b0; em_beq <= 1'b0; em_we <= 1'b0; em_zero <= 1'b0;
      em_dst <= 5'd0; em_alu <= 32'd0; em_sd <= 32'd0; em_tgt <= 32'd0; em_pc4 <= 32'd0;
      mw_v <= 1'b0; mw_we <= 1'b0; mw_dst <= 5'd0; mw_val <= 32'd0; mw_pc4 <= 32'd0;
    end else begin
      if (take) pc <= em_tgt;
      else if (!stall) pc <= pc + 32'd4;

      if (take) fd_v <= 1'b0;
      else if (!stall) begin
        fd_v <= 1'b1;
        fd_ir <= imem[pc[AW+1:2]];
        fd_pc4 <= pc + 32'd4;
      end

      de_v <= fd_v & ~take & ~stall;
      de_lw <= is_lw; de_sw <= is_sw; de_beq <= is_beq;
      de_we <= (is_r & (rd != 5'd0)) | (is_lw & (rt != 5'd0));
      de_dst <= is_r ? rd : rt;
      de_fn <= is_r ? fn : (is_beq ? FN_SUB : FN_ADD);
      de_rs <= rs; de_rt <= rt;
      de_a <= rd_a; de_b <= rd_b; de_imm <= imm; de_pc4 <= fd_pc4;

      em_v <= de_v & ~take;
      em_lw <= de_lw; em_sw <= de_sw; em_beq <= de_beq; em_we <= de_we;
      em_zero <= (alu == 32'd0);
      em_dst <= de_dst; em_alu <= alu; em_sd <= fb;
      em_tgt <= de_pc4 + {de_imm[29:0], 2'b00};
      em_pc4 <= de_pc4;

      mw_v <= em_v;
      mw_we <= em_we;
      mw_dst <= em_dst;
      mw_val <= em_lw ? mem_rd : em_alu;
      mw_pc4 <= em_pc4;
    end
  end

  assign ret_valid = mw_v;
  assign ret_pc = mw_pc4 - 32'd4;
  assign ret_we = mw_v & mw_we;
  assign ret_rd = mw_dst;
  assign ret_data = mw_val;
  assign dbg_reg_val = rf[dbg_reg_sel];
  assign dbg_mem_val = dmem[dbg_mem_sel];
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ret_valid,
  input logic        ret_we,
  input logic [4:0]  ret_rd,
  input logic        stall,
  input logic        take,
  input logic [31:0] pc,
  input logic [31:0] em_tgt,
  input logic        fd_v,
  input logic        de_v,
  input logic        em_v,
  input logic [31:0] fd_ir
);
  a_r3_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_we) |-> (ret_rd != 5'd0));

  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !ret_valid);

  a_r6_stall_holds_front: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !take) |=> ($stable(pc) && $stable(fd_ir) && !de_v));

  a_r7_flush_younger: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!fd_v && !de_v && !em_v));

  a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc == $past(em_tgt)));

  a_r8_sequential_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !take) |=> (pc == $past(pc) + 32'd4));
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_we(ret_we), .ret_rd(ret_rd),
  .stall(stall), .take(take), .pc(pc), .em_tgt(em_tgt),
  .fd_v(fd_v), .de_v(de_v), .em_v(em_v), .fd_ir(fd_ir)
);

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int NRET = 150;
  localparam int LIMIT = 2000;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n = 1'b0, ld_we = 1'b0, ld_sel = 1'b0;
  logic [AW-1:0] ld_addr = '0, dbg_mem_sel = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [31:0] dbg_reg_val, dbg_mem_val, ret_pc, ret_data;
  logic ret_valid, ret_we;
  logic [4:0] ret_rd;

  pipe5_core #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val), .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_we(ret_we), .ret_rd(ret_rd), .ret_data(ret_data));

  int n_chk = 0, n_err = 0;
  logic [31:0] seed;
  logic [31:0] prog [DEPTH];
  logic [31:0] m_dmem [DEPTH];
  logic [31:0] m_reg [32];
  logic [31:0] m_pc;
  logic [4:0]  prev_lw_dst;
  logic [31:0] e_pc, e_data, e_sd;
  logic [4:0]  e_rd;
  logic [AW-1:0] e_sa;
  logic e_we, e_st, e_taken, e_stall;
  string e_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic gen(input int prof);
    int lr, ll, ls, lb;
    case (prof)
      0: begin lr = 6; ll = 9;  ls = 11; lb = 13; end
      1: begin lr = 4; ll = 10; ls = 12; lb = 13; end
      default: begin lr = 5; ll = 7; ls = 8; lb = 13; end
    endcase
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] r, f;
      logic [5:0] fnv;
      int k;
      rnd(r); rnd(f);
      k = int'(r[3:0]);
      case (f[11:9] % 5)
        0: fnv = 6'h20; 1: fnv = 6'h22; 2: fnv = 6'h24; 3: fnv = 6'h25; default: fnv = 6'h2A;
      endcase
      if (k < lr)      prog[i] = {6'h00, 2'b0, f[5:3], 2'b0, f[8:6], 2'b0, f[2:0], 5'd0, fnv};
      else if (k < ll) prog[i] = {6'h23, 2'b0, f[5:3], 2'b0, f[8:6], {10{f[16]}}, f[15:12], 2'b00};
      else if (k < ls) prog[i] = {6'h2B, 2'b0, f[5:3], 2'b0, f[8:6], {10{f[16]}}, f[15:12], 2'b00};
      else if (k < lb) prog[i] = {6'h04, 3'b0, f[4:3], 3'b0, f[7:6], {12{f[19]}}, f[19:16]};
      else if (k == 13) prog[i] = 32'd0;
      else if (k == 14) prog[i] = {6'h3F, f[25:0]};
      else prog[i] = {6'h00, 2'b0, f[5:3], 2'b0, f[8:6], 2'b0, f[2:0], 5'd0, 6'h21};
    end
  endtask

  task automatic model_step();
    logic [31:0] ir, a, b, sx, addr;
    logic [5:0] op, fn;
    logic [4:0] rs, rt, rd;
    logic isr, rsu, rtu;
    ir = prog[m_pc[AW+1:2]];
    op = ir[31:26]; fn = ir[5:0]; rs = ir[25:21]; rt = ir[20:16]; rd = ir[15:11];
    sx = {{16{ir[15]}}, ir[15:0]};
    a = (rs == 0) ? 32'd0 : m_reg[rs];
    b = (rt == 0) ? 32'd0 : m_reg[rt];
    isr = (op == 6'h00) && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A);
    rsu = isr || op == 6'h23 || op == 6'h2B || op == 6'h04;
    rtu = isr || op == 6'h2B || op == 6'h04;
    e_stall = (prev_lw_dst != 0) && ((rsu && rs == prev_lw_dst) || (rtu && rt == prev_lw_dst));
    e_pc = m_pc; e_we = 1'b0; e_rd = 5'd0; e_data = 32'd0; e_st = 1'b0; e_taken = 1'b0;
    e_sa = '0; e_sd = 32'd0; e_tag = "R11 no-op";
    m_pc = m_pc + 32'd4;
    if (isr) begin
      e_tag = "R1/R4/R5 alu result";
      case (fn)
        6'h20: e_data = a + b;
        6'h22: e_data = a - b;
        6'h24: e_data = a & b;
        6'h25: e_data = a | b;
        default: e_data = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
      e_rd = rd; e_we = (rd != 0);
    end else if (op == 6'h23) begin
      e_tag = "R2/R4/R5 load result";
      addr = a + sx;
      e_data = m_dmem[addr[AW+1:2]];
      e_rd = rt; e_we = (rt != 0);
    end else if (op == 6'h2B) begin
      e_tag = "R2/R4 store";
      addr = a + sx;
      e_st = 1'b1; e_sa = addr[AW+1:2]; e_sd = b;
      m_dmem[e_sa] = b;
    end else if (op == 6'h04) begin
      e_tag = "R7 branch";
      if (a == b) begin
        e_taken = 1'b1;
        m_pc = m_pc + {sx[29:0], 2'b00};
      end
    end
    if (e_we) m_reg[e_rd] = e_data;
    prev_lw_dst = (op == 6'h23 && rt != 0) ? rt : 5'd0;
  endtask

  task automatic run_prog(input int prof, input logic [31:0] s);
    int cyc, nret, last_cyc;
    bit prev_taken;
    seed = s;
    gen(prof);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      m_dmem[i] = (32'h01010101 * i) ^ s;
      @(negedge clk);
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = AW'(i); ld_data = prog[i];
      @(negedge clk);
      ld_sel = 1'b1; ld_data = m_dmem[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk(ret_valid == 1'b0, "R9 retire idle in reset", {31'd0, ret_valid}, 32'd0);
    for (int r = 1; r < 32; r += 5) begin
      dbg_reg_sel = 5'(r);
      #1;
      chk(dbg_reg_val == 32'd0, "R9 register cleared", dbg_reg_val, 32'd0);
    end
    for (int i = 0; i < DEPTH; i += 9) begin
      dbg_mem_sel = AW'(i);
      #1;
      chk(dbg_mem_val == m_dmem[i], "R10 data preload", dbg_mem_val, m_dmem[i]);
    end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_pc = 32'd0; prev_lw_dst = 5'd0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; nret = 0; last_cyc = 0; prev_taken = 1'b0;
    while (nret < NRET && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (ret_valid) begin
        int exp_cyc;
        string ctag;
        model_step();
        if (nret == 0) begin exp_cyc = 4; ctag = "R8 first retire cycle"; end
        else if (prev_taken) begin exp_cyc = last_cyc + 4; ctag = "R7 taken-branch penalty"; end
        else if (e_stall) begin exp_cyc = last_cyc + 2; ctag = "R6 load-use bubble"; end
        else begin exp_cyc = last_cyc + 1; ctag = "R8 back-to-back retire"; end
        chk(cyc == exp_cyc, ctag, 32'(cyc), 32'(exp_cyc));
        chk(ret_pc == e_pc, "R7/R8 retire order pc", ret_pc, e_pc);
        chk(ret_we == e_we, "R3/R11 write flag", {31'd0, ret_we}, {31'd0, e_we});
        if (e_we) begin
          chk(ret_rd == e_rd, "R1/R2 destination", {27'd0, ret_rd}, {27'd0, e_rd});
          chk(ret_data == e_data, e_tag, ret_data, e_data);
        end
        if (e_st) begin
          dbg_mem_sel = e_sa;
          #1;
          chk(dbg_mem_val == e_sd, e_tag, dbg_mem_val, e_sd);
        end
        last_cyc = cyc;
        prev_taken = e_taken;
        nret++;
      end
    end
    chk(nret == NRET, "R8 retire progress", 32'(nret), 32'(NRET));
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    run_prog(0, 32'h1234_5678);
    run_prog(1, 32'h0BAD_F00D);
    run_prog(2, 32'h7EED_1357);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule